// File: doc/BRIEF.md
# Actuator Drive Selector with Sweep Generator

This block chooses what drives a cavity actuator in a digital feedback loop. In scan mode it produces a sawtooth sweep of programmable step and amplitude, and there is no feedback. While the sweep runs, the error signal is watched so that a suitable offset can be found. In lock mode the controller's output drives the actuator, and the loop is closed. The same programmable offset is added in both modes. The sum is saturated to the output width.

The mode comes from a single request bit written by software. The block acts on it only at a sample boundary. On each entry into lock mode, the block gives the controller a one-cycle reset so that its filter state starts clean. The block also reports the sweep position with each output sample, and it pulses a marker on the first sample of each new sweep. Error captures can therefore be lined up with the ramp.

Top module: `act_drive_sel`

## Requirements
- R1: After reset, `act_o`, `sweep_pos_o`, `lock_o`, `sweep_start_o` and `ctrl_rst_o` are all zero, and the internal 32-bit phase accumulator is zero.
- R2: In scan mode, each cycle with `sample_en_i` high adds `step_i` to the 32-bit accumulator (modulo 2^32). `sweep_pos_o` takes the ramp value of the accumulator as it stood before that add. The ramp value is the upper 16 bits with the top bit inverted: accumulator 0 gives -32768, and the largest accumulator value gives 32767.
- R3: In scan mode, `act_o` becomes floor(ramp * `sweep_amp_i` / 65536) + `offset_i`, saturated, on the same sample. `sweep_amp_i` is unsigned.
- R4: In lock mode, `act_o` becomes `ctrl_i` + `offset_i`, saturated, on each sample. The accumulator and `sweep_pos_o` hold.
- R5: `lock_o` takes the value of `lock_req_i` only on cycles with `sample_en_i` high. The sample that makes the change already uses the new mode.
- R6: `ctrl_rst_o` is high for exactly the one cycle after the sample on which `lock_o` goes from 0 to 1. It never rises at any other time.
- R7: `sweep_start_o` is high for one cycle, together with the first scan-mode output sample whose ramp comes after an accumulator wrap. It is never high in lock mode.
- R8: Sums above 32767 give 32767, and sums below -32768 give -32768.
- R9: On cycles without `sample_en_i`, `act_o` and `sweep_pos_o` hold, and `sweep_start_o` and `ctrl_rst_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Sample strobe |
| lock_req_i | input | 1 | Requested mode: 1 selects lock, 0 selects scan |
| step_i | input | 32 | Accumulator increment per sample |
| sweep_amp_i | input | 16 | Unsigned sweep gain, fraction of 65536 |
| offset_i | input | 16 | Signed offset added to the drive |
| ctrl_i | input | 16 | Signed controller output |
| act_o | output | 16 | Signed saturated actuator drive |
| sweep_pos_o | output | 16 | Signed ramp value used for the current sample |
| sweep_start_o | output | 1 | First sample of a new sweep |
| lock_o | output | 1 | Current mode: 1 means lock |
| ctrl_rst_o | output | 1 | One-cycle controller reset on entry to lock |

## Verification
Any error in the accumulator shows up on the next scan sample, because `sweep_pos_o` and `act_o` both carry the pre-add ramp. A wrong step or a missed wrap therefore differs from the bench model within one sample. If the mode register were wrongly updated between strobes, `lock_o` would change on a non-sample cycle, or `ctrl_rst_o` would pulse out of place, which is visible at once. Saturation and offset faults appear on the same sample as the overflowing sum. The bench drives the extremes of offset, amplitude and controller value to reach them.

// File: rtl/act_pkg.sv
package act_pkg;
  typedef enum logic {
    MODE_SCAN = 1'b0,
    MODE_LOCK = 1'b1
  } drive_mode_e;
endpackage

// File: rtl/act_ramp_gen.sv
module act_ramp_gen #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_i,
  input  logic                 run_i,
  input  logic [AW-1:0]        step_i,
  output logic signed [DW-1:0] ramp_o,
  output logic                 wrapped_o
);
  logic [AW-1:0] acc_q;
  logic [AW:0]   sum;

  assign sum    = {1'b0, acc_q} + {1'b0, step_i};
  // offset-binary to signed: zero phase maps to most negative
  assign ramp_o = {~acc_q[AW-1], acc_q[AW-2:AW-DW]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q     <= '0;
      wrapped_o <= 1'b0;
    end else if (sample_i) begin
      if (run_i) begin
        acc_q     <= sum[AW-1:0];
        wrapped_o <= sum[AW];
      end else begin
        wrapped_o <= 1'b0;
      end
    end
  end

  p_acc_frozen_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sample_i && run_i) |=> $stable(acc_q));
endmodule

// File: rtl/act_mode_ctl.sv
module act_mode_ctl
  import act_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sample_i,
  input  logic        lock_req_i,
  output drive_mode_e mode_o,
  output logic        ctrl_rst_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o     <= MODE_SCAN;
      ctrl_rst_o <= 1'b0;
    end else begin
      ctrl_rst_o <= sample_i && lock_req_i && (mode_o == MODE_SCAN);
      if (sample_i) mode_o <= lock_req_i ? MODE_LOCK : MODE_SCAN;
    end
  end

  p_mode_on_sample_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(mode_o));
  p_ctrl_rst_entry_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_rst_o |-> (mode_o == MODE_LOCK) && $past(mode_o == MODE_SCAN));
endmodule

// File: rtl/act_drive_sel.sv
module act_drive_sel
  import act_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_en_i,
  input  logic                 lock_req_i,
  input  logic [AW-1:0]        step_i,
  input  logic [DW-1:0]        sweep_amp_i,
  input  logic signed [DW-1:0] offset_i,
  input  logic signed [DW-1:0] ctrl_i,
  output logic signed [DW-1:0] act_o,
  output logic signed [DW-1:0] sweep_pos_o,
  output logic                 sweep_start_o,
  output logic                 lock_o,
  output logic                 ctrl_rst_o
);
  localparam int unsigned PW = 2*DW + 1;
  localparam logic signed [DW:0] MAXV = {2'b00, {(DW-1){1'b1}}};
  localparam logic signed [DW:0] MINV = {2'b11, {(DW-1){1'b0}}};

  drive_mode_e           mode;
  logic signed [DW-1:0]  ramp;
  logic                  wrapped;
  logic signed [PW-1:0]  prod;
  logic signed [DW-1:0]  sweep;
  logic signed [DW-1:0]  src;
  logic signed [DW:0]    sum;
  logic signed [DW-1:0]  sat;

  act_ramp_gen #(.AW(AW), .DW(DW)) u_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sample_i  (sample_en_i),
    .run_i     (!lock_req_i),
    .step_i    (step_i),
    .ramp_o    (ramp),
    .wrapped_o (wrapped)
  );

  act_mode_ctl u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample_en_i),
    .lock_req_i (lock_req_i),
    .mode_o     (mode),
    .ctrl_rst_o (ctrl_rst_o)
  );

  assign lock_o = (mode == MODE_LOCK);
  assign prod   = ramp * $signed({1'b0, sweep_amp_i});
  assign sweep  = prod[2*DW-1:DW];
  assign src    = lock_req_i ? ctrl_i : sweep;
  assign sum    = {src[DW-1], src} + {offset_i[DW-1], offset_i};

  always_comb begin
    if (sum > MAXV)      sat = MAXV[DW-1:0];
    else if (sum < MINV) sat = MINV[DW-1:0];
    else                 sat = sum[DW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o         <= '0;
      sweep_pos_o   <= '0;
      sweep_start_o <= 1'b0;
    end else begin
      sweep_start_o <= sample_en_i && !lock_req_i && wrapped;
      if (sample_en_i) begin
        act_o <= sat;
        if (!lock_req_i) sweep_pos_o <= ramp;
      end
    end
  end

  p_start_scan_only_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sweep_start_o |-> !lock_o);
  p_hold_act_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> $stable(act_o) && $stable(sweep_pos_o) && !sweep_start_o && !ctrl_rst_o);
  p_lock_pos_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o && $past(lock_o) |-> $stable(sweep_pos_o));
endmodule

// File: tb/act_drive_sel_tb_top.sv
module act_drive_sel_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_en = 1'b0;
  logic lock_req = 1'b0;
  logic [31:0] step = '0;
  logic [15:0] amp = '0;
  logic signed [15:0] offset = '0;
  logic signed [15:0] ctrl = '0;
  logic signed [15:0] act, pos;
  logic start, lock, crst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // model state
  logic [31:0] m_acc = '0;
  bit m_wr = 1'b0, m_lock = 1'b0;
  logic signed [15:0] m_act = '0, m_pos = '0;
  bit m_start = 1'b0, m_crst = 1'b0;

  always #2.5 clk = ~clk;

  act_drive_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_en_i(sample_en), .lock_req_i(lock_req),
    .step_i(step), .sweep_amp_i(amp), .offset_i(offset), .ctrl_i(ctrl),
    .act_o(act), .sweep_pos_o(pos), .sweep_start_o(start), .lock_o(lock),
    .ctrl_rst_o(crst)
  );

  function automatic logic signed [15:0] ramp_of(logic [31:0] a);
    return {~a[31], a[30:16]};
  endfunction

  function automatic logic signed [15:0] sat16(longint s);
    if (s > 32767) return 16'sh7fff;
    if (s < -32768) return 16'sh8000;
    return 16'(s);
  endfunction

  task automatic chk(longint act_v, longint exp_v, string tag);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act_v, exp_v);
    end
  endtask

  task automatic chk_all(string tag);
    chk(act, m_act, {tag, " act"});
    chk(pos, m_pos, {tag, " pos"});
    chk(start, m_start, {tag, " start"});
    chk(lock, m_lock, {tag, " lock"});
    chk(crst, m_crst, {tag, " ctrl_rst"});
  endtask

  task automatic do_sample(string tag);
    longint p;
    bit nl;
    @(negedge clk) sample_en = 1'b1;
    @(negedge clk) sample_en = 1'b0;
    nl = lock_req;
    m_crst = nl && !m_lock;
    m_start = !nl && m_wr;
    if (nl) m_act = sat16(longint'(ctrl) + longint'(offset));
    else begin
      p = longint'(ramp_of(m_acc)) * longint'({1'b0, amp});
      m_act = sat16((p >>> 16) + longint'(offset));
      m_pos = ramp_of(m_acc);
    end
    if (!nl) begin
      m_wr = (33'(m_acc) + 33'(step)) > 33'h0_ffff_ffff;
      m_acc = m_acc + step;
    end else m_wr = 1'b0;
    m_lock = nl;
    chk_all(tag);
  endtask

  task automatic t_reset();
    chk(act, 0, "R1 act");
    chk(pos, 0, "R1 pos");
    chk(start, 0, "R1 start");
    chk(lock, 0, "R1 lock");
    chk(crst, 0, "R1 ctrl_rst");
  endtask

  task automatic t_scan();
    step = 32'h0123_4567; amp = 16'hffff; offset = 16'sd100;
    for (int i = 0; i < 6; i++) do_sample("R2 R3 scan");
    amp = 16'h4000; offset = -16'sd2000;
    for (int i = 0; i < 4; i++) do_sample("R3 scan amp");
  endtask

  task automatic t_wrap();
    step = 32'h4000_0000; amp = 16'h8000; offset = 16'sd0;
    for (int i = 0; i < 10; i++) do_sample("R7 wrap");
  endtask

  task automatic t_sat();
    step = 32'h1000_0000; amp = 16'hffff; offset = 16'sh7000;
    for (int i = 0; i < 8; i++) do_sample("R8 scan sat");
    offset = -16'sh7000;
    for (int i = 0; i < 8; i++) do_sample("R8 scan sat neg");
  endtask

  task automatic t_hold();
    offset = 16'sd5;
    @(negedge clk) lock_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_all("R5 R9 hold");
    end
    lock_req = 1'b0;
  endtask

  task automatic t_lock();
    lock_req = 1'b1; ctrl = 16'sd1234; offset = 16'sd10;
    do_sample("R6 lock entry");
    @(negedge clk);
    m_crst = 1'b0;
    chk_all("R6 ctrl_rst one cycle");
    ctrl = -16'sd300;
    do_sample("R4 lock");
    ctrl = 16'sh7f00; offset = 16'sh0200;
    do_sample("R8 lock sat pos");
    ctrl = -16'sh7f00; offset = -16'sh0200;
    do_sample("R8 lock sat neg");
    ctrl = 16'sd7; offset = 16'sd0;
    do_sample("R4 lock again no R6 pulse");
    lock_req = 1'b0;
    step = 32'h0800_0000; amp = 16'hc000;
    do_sample("R5 back to scan");
    do_sample("R2 scan resumes");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_scan();
    t_wrap();
    t_sat();
    t_hold();
    t_lock();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule